// File: doc/BRIEF.md
# Flash Page Load Sequencer

This block sits on the host side of a NAND-style flash device that exposes a memory-mapped register file of 16-bit words. It runs one complete page-load transaction at a time. A single start pulse carries the target location: block number, die bit, page, sector within the page, which of the two on-chip buffer RAMs to fill, the first buffer sector and the number of sectors. The block then writes the address and buffer registers and issues the load command. It waits for the device's interrupt flag, reads the controller status, streams the loaded words out of the buffer RAM and, on every path, clears the interrupt flag before it reports completion.

The device side is a single-outstanding read/write port. The block holds each request until the device acknowledges it. The host side gets a valid/ready word stream that marks the final word, a busy level, and a one-cycle done pulse. The pulse carries an ECC-error flag and a poll-timeout flag.

The controller has these states: IDLE, W_BLK (block register write), W_PAGE (page/sector register write), W_BSEL (buffer sector register write), W_DBS (buffer-select write, dual-die builds only), W_CMD (command write), POLL (interrupt register read), STAT (status read), READ (buffer word read), PUSH (word offered on the stream), CLR (interrupt clear) and DONE. Its transitions are:
- IDLE goes to W_BLK on start.
- Each write state goes to the next one on acknowledge, in the order W_BLK, W_PAGE, W_BSEL, W_DBS (or straight to W_CMD when that state is absent), W_CMD, POLL.
- POLL goes to STAT when bit 15 reads high. It goes to CLR on timeout, and otherwise stays in POLL.
- STAT goes to CLR when error bit 10 is set, and otherwise to READ.
- READ goes to PUSH on acknowledge.
- PUSH goes to READ when its word is accepted, or to CLR when the accepted word was the last one.
- CLR goes to DONE on acknowledge.
- DONE goes to IDLE.

Top module: `flash_load_seq`

## Requirements
- R1: After a start pulse in idle, the first bus transaction is a write to 0xF100. Its data holds the block number in the low bits and the die bit at bit 15.
- R2: The second transaction writes 0xF107 with the sector-in-page in bits [1:0] and the page number from bit 2 upward.
- R3: The third transaction writes 0xF200 with the sector count in bits [1:0] and the buffer sector index {buffer, start sector} in bits [10:8].
- R4: In a dual-die build, the fourth transaction writes 0xF101 with the buffer select at bit 15.
- R5: The next transaction writes the configured load command value (0x0000 or 0x0013) to 0xF220.
- R6: The block then reads 0xF241 repeatedly until a read returns bit 15 high. After that read it reads the status register 0xF240 once.
- R7: A bus request stays asserted, with address, direction and write data unchanged, until it is acknowledged.
- R8: A status read with bit 10 set ends the transaction with the error flag raised on the done pulse. In that case no buffer word is read and no stream word is sent. Other status bits have no effect.
- R9: When the number of poll reads returning bit 15 low reaches the timeout limit (a limit of 0 counts as 1), the block stops polling and skips the status read and the readout. It raises the timeout flag on the done pulse.
- R10: Without an error, the block reads n sectors of SECT_WORDS words each, where n is the sector count and a count of 0 means 4. The word address is BUF_BASE + ((buffer·4 + (start+k) mod 4)·SECT_WORDS) + w. Reads go in order of sector k and then word w, and each word is passed unchanged to the stream.
- R11: Only the final stream word carries the last flag. A word that is not accepted stays offered with the same data and flag.
- R12: Every path ends with a write of 0x0000 to 0xF241, followed by a one-cycle done pulse. A start pulse while busy is ignored.
- R13: Out of reset the block is idle: no bus request, no stream word, no done, busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken in idle |
| blk_i | input | BLK_W | Flash block number |
| die_i | input | 1 | Die select bit |
| page_i | input | PAGE_W | Page within the block |
| sect_i | input | SIDX_W | Sector within the page |
| buf_i | input | 1 | Buffer RAM select |
| bsa_i | input | SIDX_W | First buffer sector |
| bsc_i | input | SIDX_W | Sector count, 0 means 4 |
| tmo_lim_i | input | TO_W | Poll timeout limit in low reads |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | ECC error, valid with done |
| tout_o | output | 1 | Poll timeout, valid with done |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | 16 | Bus word address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_ack_i | input | 1 | Bus acknowledge |
| bus_rdata_i | input | 16 | Bus read data, valid with acknowledge |
| dout_valid_o | output | 1 | Stream word valid |
| dout_data_o | output | 16 | Stream word |
| dout_last_o | output | 1 | Final word of the load |
| dout_ready_i | input | 1 | Stream consumer ready |

## Verification
A bus transaction completes at the clock edge where the acknowledge is high. The next request appears in the cycle that follows that edge. A buffer word is offered on the stream one cycle after its read is acknowledged. The done pulse arrives one cycle after the clearing write is acknowledged. The bench's device model raises the acknowledge on a falling edge and logs the transaction in that same half-cycle. The bench then compares the whole ordered log, stream and done flags against a list built arithmetically from the inputs. Stream words and the done pulse are captured on falling edges, and ready is changed before valid is sampled, so each capture matches the transfer at the next rising edge.

// File: rtl/flash_load_pkg.sv
package flash_load_pkg;

    localparam logic [15:0] REG_BLK  = 16'hF100;
    localparam logic [15:0] REG_DBS  = 16'hF101;
    localparam logic [15:0] REG_PAGE = 16'hF107;
    localparam logic [15:0] REG_BSEL = 16'hF200;
    localparam logic [15:0] REG_CMD  = 16'hF220;
    localparam logic [15:0] REG_STAT = 16'hF240;
    localparam logic [15:0] REG_INT  = 16'hF241;

    localparam int INT_BIT = 15;
    localparam int ERR_BIT = 10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_BLK,
        ST_W_PAGE,
        ST_W_BSEL,
        ST_W_DBS,
        ST_W_CMD,
        ST_POLL,
        ST_STAT,
        ST_READ,
        ST_PUSH,
        ST_CLR,
        ST_DONE
    } fl_state_e;

endpackage

// File: rtl/flash_load_fmt.sv
module flash_load_fmt #(
    parameter int BLK_W    = 10,
    parameter int PAGE_W   = 6,
    parameter int SIDX_W   = 2,
    parameter bit DUAL_DIE = 1'b1
) (
    input  logic [BLK_W-1:0]  blk_i,
    input  logic              die_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [SIDX_W-1:0] sect_i,
    input  logic              buf_i,
    input  logic [SIDX_W-1:0] bsa_i,
    input  logic [SIDX_W-1:0] bsc_i,
    output logic [15:0]       d_blk_o,
    output logic [15:0]       d_page_o,
    output logic [15:0]       d_bsel_o,
    output logic [15:0]       d_dbs_o
);

    localparam int BIDX_W = SIDX_W + 1;

    logic [15:0] blk_field;
    assign blk_field = 16'(blk_i);

    generate
        if (DUAL_DIE) begin : g_dual
            assign d_blk_o = {die_i, blk_field[14:0]};
            assign d_dbs_o = {buf_i, 15'd0};
        end else begin : g_single
            logic unused_die;
            assign unused_die = die_i;
            assign d_blk_o    = {1'b0, blk_field[14:0]};
            assign d_dbs_o    = 16'd0;
        end
    endgenerate

    assign d_page_o = 16'({page_i, sect_i});

    logic [BIDX_W-1:0] bidx;
    assign bidx     = {buf_i, bsa_i};
    assign d_bsel_o = (16'(bidx) << 8) | 16'(bsc_i);

endmodule

// File: rtl/flash_load_poll_timer.sv
module flash_load_poll_timer #(
    parameter int TO_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [TO_W-1:0] lim_i,
    input  logic            low_i,
    output logic            expire_o
);

    logic [TO_W-1:0] cnt_q;
    logic [TO_W-1:0] lim_q;
    logic [TO_W:0]   eff_lim;

    assign eff_lim  = (lim_q == '0) ? (TO_W+1)'(1) : {1'b0, lim_q};
    assign expire_o = low_i && (({1'b0, cnt_q} + (TO_W+1)'(1)) >= eff_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
            lim_q <= lim_i;
        end else if (low_i && !expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the count of low reads never reaches the limit while polling
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} < eff_lim);

endmodule

// File: rtl/flash_load_rd_addr.sv
module flash_load_rd_addr #(
    parameter int          SECT_WORDS = 256,
    parameter int          SECTS      = 4,
    parameter logic [15:0] BUF_BASE   = 16'h0200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic                       adv_i,
    input  logic                       buf_i,
    input  logic [$clog2(SECTS)-1:0]   bsa_i,
    input  logic [$clog2(SECTS)-1:0]   bsc_i,
    output logic [15:0]                addr_o,
    output logic                       last_o
);

    localparam int SIDX_W  = $clog2(SECTS);
    localparam int SECT_AW = $clog2(SECT_WORDS);
    localparam logic [SECT_AW-1:0] W_MAX = SECT_AW'(SECT_WORDS - 1);

    logic              buf_q;
    logic [SIDX_W-1:0] bsa_q;
    logic [SIDX_W:0]   nsec_q;
    logic [SIDX_W-1:0] sk_q;
    logic [SECT_AW-1:0] w_q;
    logic [SIDX_W-1:0] sidx;

    assign sidx   = bsa_q + sk_q;
    assign addr_o = BUF_BASE + 16'({buf_q, sidx, w_q});
    assign last_o = (w_q == W_MAX) && ({1'b0, sk_q} == (nsec_q - (SIDX_W+1)'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= 1'b0;
            bsa_q  <= '0;
            nsec_q <= (SIDX_W+1)'(1);
            sk_q   <= '0;
            w_q    <= '0;
        end else if (load_i) begin
            buf_q  <= buf_i;
            bsa_q  <= bsa_i;
            nsec_q <= (bsc_i == '0) ? (SIDX_W+1)'(SECTS) : {1'b0, bsc_i};
            sk_q   <= '0;
            w_q    <= '0;
        end else if (adv_i) begin
            if (w_q == W_MAX) begin
                w_q  <= '0;
                sk_q <= sk_q + 1'b1;
            end else begin
                w_q <= w_q + 1'b1;
            end
        end
    end

    // R10: every accepted word that is not the last moves the read address
    p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !last_o && !load_i |=> addr_o != $past(addr_o));

endmodule

// File: rtl/flash_load_seq.sv
module flash_load_seq
    import flash_load_pkg::*;
#(
    parameter int          BLK_W      = 10,
    parameter int          PAGE_W     = 6,
    parameter int          SECT_WORDS = 256,
    parameter int          TO_W       = 12,
    parameter bit          DUAL_DIE   = 1'b1,
    parameter logic [15:0] LOAD_CMD   = 16'h0000,
    parameter logic [15:0] BUF_BASE   = 16'h0200,
    localparam int         SIDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic              die_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [SIDX_W-1:0] sect_i,
    input  logic              buf_i,
    input  logic [SIDX_W-1:0] bsa_i,
    input  logic [SIDX_W-1:0] bsc_i,
    input  logic [TO_W-1:0]   tmo_lim_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              tout_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [15:0]       bus_addr_o,
    output logic [15:0]       bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [15:0]       bus_rdata_i,
    output logic              dout_valid_o,
    output logic [15:0]       dout_data_o,
    output logic              dout_last_o,
    input  logic              dout_ready_i
);

    localparam int SECTS = 1 << SIDX_W;

    fl_state_e st_q, st_d;

    logic [BLK_W-1:0]  blk_q;
    logic              die_q;
    logic [PAGE_W-1:0] page_q;
    logic [SIDX_W-1:0] sect_q;
    logic              buf_q;
    logic [SIDX_W-1:0] bsa_q;
    logic [SIDX_W-1:0] bsc_q;
    logic              err_q;
    logic              tout_q;
    logic [15:0]       word_q;

    logic        accept;
    logic        xfer;
    logic        int_hi;
    logic        low_read;
    logic        expire;
    logic        rd_load;
    logic        rd_adv;
    logic [15:0] rd_addr;
    logic        rd_last;
    logic [15:0] d_blk, d_page, d_bsel, d_dbs;

    assign accept   = (st_q == ST_IDLE) && start_i;
    assign xfer     = bus_req_o && bus_ack_i;
    assign int_hi   = bus_rdata_i[INT_BIT];
    assign low_read = (st_q == ST_POLL) && xfer && !int_hi;
    assign rd_load  = (st_q == ST_STAT) && xfer;
    assign rd_adv   = (st_q == ST_PUSH) && dout_ready_i;

    flash_load_fmt #(
        .BLK_W    (BLK_W),
        .PAGE_W   (PAGE_W),
        .SIDX_W   (SIDX_W),
        .DUAL_DIE (DUAL_DIE)
    ) fmt_i (
        .blk_i    (blk_q),
        .die_i    (die_q),
        .page_i   (page_q),
        .sect_i   (sect_q),
        .buf_i    (buf_q),
        .bsa_i    (bsa_q),
        .bsc_i    (bsc_q),
        .d_blk_o  (d_blk),
        .d_page_o (d_page),
        .d_bsel_o (d_bsel),
        .d_dbs_o  (d_dbs)
    );

    flash_load_poll_timer #(
        .TO_W (TO_W)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (accept),
        .lim_i    (tmo_lim_i),
        .low_i    (low_read),
        .expire_o (expire)
    );

    flash_load_rd_addr #(
        .SECT_WORDS (SECT_WORDS),
        .SECTS      (SECTS),
        .BUF_BASE   (BUF_BASE)
    ) rda_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rd_load),
        .adv_i  (rd_adv),
        .buf_i  (buf_q),
        .bsa_i  (bsa_q),
        .bsc_i  (bsc_q),
        .addr_o (rd_addr),
        .last_o (rd_last)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_W_BLK;
            ST_W_BLK:  if (xfer) st_d = ST_W_PAGE;
            ST_W_PAGE: if (xfer) st_d = ST_W_BSEL;
            ST_W_BSEL: if (xfer) st_d = DUAL_DIE ? ST_W_DBS : ST_W_CMD;
            ST_W_DBS:  if (xfer) st_d = ST_W_CMD;
            ST_W_CMD:  if (xfer) st_d = ST_POLL;
            ST_POLL: begin
                if (xfer) begin
                    if (int_hi)      st_d = ST_STAT;
                    else if (expire) st_d = ST_CLR;
                end
            end
            ST_STAT: begin
                if (xfer) st_d = bus_rdata_i[ERR_BIT] ? ST_CLR : ST_READ;
            end
            ST_READ:   if (xfer) st_d = ST_PUSH;
            ST_PUSH: begin
                if (dout_ready_i) st_d = rd_last ? ST_CLR : ST_READ;
            end
            ST_CLR:    if (xfer) st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            blk_q  <= '0;
            die_q  <= 1'b0;
            page_q <= '0;
            sect_q <= '0;
            buf_q  <= 1'b0;
            bsa_q  <= '0;
            bsc_q  <= '0;
            err_q  <= 1'b0;
            tout_q <= 1'b0;
            word_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                blk_q  <= blk_i;
                die_q  <= die_i;
                page_q <= page_i;
                sect_q <= sect_i;
                buf_q  <= buf_i;
                bsa_q  <= bsa_i;
                bsc_q  <= bsc_i;
                err_q  <= 1'b0;
                tout_q <= 1'b0;
            end
            if (rd_load && bus_rdata_i[ERR_BIT]) err_q <= 1'b1;
            if (low_read && expire) tout_q <= 1'b1;
            if ((st_q == ST_READ) && xfer) word_q <= bus_rdata_i;
        end
    end

    // outputs
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = 16'd0;
        bus_wdata_o = 16'd0;
        unique case (st_q)
            ST_W_BLK:  begin bus_req_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = REG_BLK;  bus_wdata_o = d_blk;  end
            ST_W_PAGE: begin bus_req_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = REG_PAGE; bus_wdata_o = d_page; end
            ST_W_BSEL: begin bus_req_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = REG_BSEL; bus_wdata_o = d_bsel; end
            ST_W_DBS:  begin bus_req_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = REG_DBS;  bus_wdata_o = d_dbs;  end
            ST_W_CMD:  begin bus_req_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = REG_CMD;  bus_wdata_o = LOAD_CMD; end
            ST_POLL:   begin bus_req_o = 1'b1; bus_addr_o = REG_INT;  end
            ST_STAT:   begin bus_req_o = 1'b1; bus_addr_o = REG_STAT; end
            ST_READ:   begin bus_req_o = 1'b1; bus_addr_o = rd_addr;  end
            ST_CLR:    begin bus_req_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = REG_INT; bus_wdata_o = 16'd0; end
            default:   ;
        endcase
    end

    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = (st_q == ST_DONE);
    assign err_o        = done_o && err_q;
    assign tout_o       = done_o && tout_q;
    assign dout_valid_o = (st_q == ST_PUSH);
    assign dout_data_o  = word_q;
    assign dout_last_o  = (st_q == ST_PUSH) && rd_last;

    // R7: a pending request holds its address, direction and data
    p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                     && $stable(bus_we_o) && $stable(bus_wdata_o));

    // R11: an offered word stays until taken
    p_stream_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid_o && !dout_ready_i |=> dout_valid_o && $stable(dout_data_o)
                                          && $stable(dout_last_o));

    // R8 / R9: no stream word after an error or a timeout
    p_no_stream_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid_o |-> !err_q && !tout_q);

    // R12: done follows an acknowledged clear of the interrupt register
    p_done_after_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_req_o && bus_ack_i && bus_we_o
                                && (bus_addr_o == REG_INT) && (bus_wdata_o == 16'd0)));

    // R12: done is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/flash_load_seq_tb_top.sv
module flash_load_seq_tb_top;

    localparam int SW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        start;
    logic [9:0]  blk;
    logic        die;
    logic [5:0]  page;
    logic [1:0]  sect;
    logic        bufs;
    logic [1:0]  bsa;
    logic [1:0]  bsc;
    logic [7:0]  lim;
    logic        busy, done, err, tout;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr, bus_wdata;
    logic        ack = 1'b0;
    logic [15:0] rdata = 16'd0;
    logic        dout_valid, dout_last;
    logic [15:0] dout_data;
    logic        dout_ready = 1'b1;

    flash_load_seq #(
        .SECT_WORDS (SW),
        .TO_W       (8),
        .LOAD_CMD   (16'h0013)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_i(blk), .die_i(die),
        .page_i(page), .sect_i(sect), .buf_i(bufs), .bsa_i(bsa), .bsc_i(bsc),
        .tmo_lim_i(lim), .busy_o(busy), .done_o(done), .err_o(err), .tout_o(tout),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_ack_i(ack), .bus_rdata_i(rdata),
        .dout_valid_o(dout_valid), .dout_data_o(dout_data), .dout_last_o(dout_last),
        .dout_ready_i(dout_ready)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] buf_val(input logic [15:0] a);
        return (a * 16'd37) ^ 16'h6B19;
    endfunction

    // device model
    int          nlog = 0;
    logic        lg_we   [128];
    logic [15:0] lg_addr [128];
    logic [15:0] lg_data [128];
    int          lat_cnt = 0;
    int          poll_n = 0;
    int          poll_p = 0;
    logic [15:0] st_val = 16'd0;

    always @(negedge clk) begin
        if (ack) begin
            ack = 1'b0;
        end else if (bus_req && rst_n) begin
            if (lat_cnt < (nlog % 3)) begin
                lat_cnt++;
            end else begin
                lat_cnt = 0;
                if (nlog < 128) begin
                    lg_we[nlog]   = bus_we;
                    lg_addr[nlog] = bus_addr;
                    lg_data[nlog] = bus_wdata;
                end
                nlog++;
                if (!bus_we) begin
                    if (bus_addr == 16'hF241) begin
                        rdata = (poll_n >= poll_p) ? 16'h8000 : 16'h0001;
                        poll_n++;
                    end else if (bus_addr == 16'hF240) begin
                        rdata = st_val;
                    end else begin
                        rdata = buf_val(bus_addr);
                    end
                end
                ack = 1'b1;
            end
        end
    end

    // stream sink and done capture
    int          cyc = 0;
    bit          rdy_slow = 1'b0;
    int          ns = 0;
    logic [15:0] sd [64];
    logic        sl [64];
    int          n_done = 0;
    logic        g_err = 1'b0;
    logic        g_tout = 1'b0;

    always @(negedge clk) begin
        cyc++;
        dout_ready = rdy_slow ? ((cyc % 3) != 0) : 1'b1;
        if (dout_valid && dout_ready) begin
            if (ns < 64) begin
                sd[ns] = dout_data;
                sl[ns] = dout_last;
            end
            ns++;
        end
        if (done) begin
            n_done++;
            g_err  = err;
            g_tout = tout;
        end
    end

    // expected transaction list
    int          nex;
    logic        ex_we   [128];
    logic [15:0] ex_addr [128];
    logic [15:0] ex_data [128];
    string       ex_tag  [128];

    task automatic add(input logic we, input logic [15:0] a, input logic [15:0] d, input string t);
        ex_we[nex]   = we;
        ex_addr[nex] = a;
        ex_data[nex] = d;
        ex_tag[nex]  = t;
        nex++;
    endtask

    task automatic run_case(input int b, input int sa, input int sc, input int bk, input int dd,
                            input int pg, input int sx, input int pp, input int lm,
                            input logic [15:0] sv, input bit slow, input bit restart);
        int leff;
        int nsec;
        int nst;
        bit e_err;
        bit e_tout;
        int wd;
        logic [15:0] ebuf [64];
        nex = 0;
        nst = 0;
        leff = (lm == 0) ? 1 : lm;
        nsec = (sc == 0) ? 4 : sc;
        add(1'b1, 16'hF100, 16'((dd << 15) | bk), "R1");
        add(1'b1, 16'hF107, 16'((pg << 2) | sx), "R2");
        add(1'b1, 16'hF200, 16'((((b << 2) | sa) << 8) | sc), "R3");
        add(1'b1, 16'hF101, 16'(b << 15), "R4");
        add(1'b1, 16'hF220, 16'h0013, "R5");
        e_tout = !(pp < leff);
        e_err  = 1'b0;
        if (!e_tout) begin
            for (int i = 0; i <= pp; i++) add(1'b0, 16'hF241, 16'd0, "R6");
            add(1'b0, 16'hF240, 16'd0, "R6");
            e_err = sv[10];
            if (!e_err) begin
                for (int k = 0; k < nsec; k++) begin
                    for (int w = 0; w < SW; w++) begin
                        logic [15:0] a;
                        a = 16'h0200 + 16'(((b * 4 + ((sa + k) % 4)) * SW) + w);
                        add(1'b0, a, 16'd0, "R10");
                        ebuf[nst] = buf_val(a);
                        nst++;
                    end
                end
            end
        end else begin
            for (int i = 0; i < leff; i++) add(1'b0, 16'hF241, 16'd0, "R9");
        end
        add(1'b1, 16'hF241, 16'h0000, "R12");

        @(negedge clk);
        nlog = 0; ns = 0; n_done = 0; poll_n = 0; lat_cnt = 0;
        poll_p = pp; st_val = sv; rdy_slow = slow;
        bufs = b[0]; bsa = 2'(sa); bsc = 2'(sc); blk = 10'(bk); die = dd[0];
        page = 6'(pg); sect = 2'(sx); lim = 8'(lm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R12", int'(busy), 1);
            bufs = ~bufs; bsa = bsa + 2'd1; bsc = bsc + 2'd1; blk = ~blk;
            page = ~page; sect = ~sect; lim = 8'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (n_done == 0 && wd < 4000) begin
            @(negedge clk);
            wd++;
        end
        chk(wd < 4000, "R12 watchdog", wd, 4000);
        repeat (6) @(negedge clk);

        chk(nlog == nex, "R12", nlog, nex);
        for (int i = 0; i < nex; i++) begin
            if (i < nlog && i < 128) begin
                chk(lg_addr[i] == ex_addr[i] && lg_we[i] == ex_we[i], ex_tag[i],
                    int'({lg_we[i], lg_addr[i]}), int'({ex_we[i], ex_addr[i]}));
                if (ex_we[i])
                    chk(lg_data[i] == ex_data[i], ex_tag[i], int'(lg_data[i]), int'(ex_data[i]));
            end
        end
        chk(ns == nst, e_err ? "R8" : "R10", ns, nst);
        for (int i = 0; i < nst && i < ns; i++) begin
            chk(sd[i] == ebuf[i], "R10", int'(sd[i]), int'(ebuf[i]));
            chk(sl[i] == (i == nst - 1), "R11", int'(sl[i]), int'(i == nst - 1));
        end
        chk(n_done == 1, "R12", n_done, 1);
        chk(g_err == e_err, "R8", int'(g_err), int'(e_err));
        chk(g_tout == e_tout, "R9", int'(g_tout), int'(e_tout));
        chk(busy == 1'b0 && bus_req == 1'b0, "R12", int'({busy, bus_req}), 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; blk = '0; die = 1'b0; page = '0; sect = '0;
        bufs = 1'b0; bsa = '0; bsc = '0; lim = 8'd5;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(bus_req == 1'b0, "R13", int'(bus_req), 0);
        chk(dout_valid == 1'b0, "R13", int'(dout_valid), 0);
        chk(done == 1'b0 && busy == 1'b0, "R13", int'({done, busy}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_req == 1'b0 && busy == 1'b0, "R13", int'({bus_req, busy}), 0);

        // sweep: buffer, start sector, count
        for (int b = 0; b < 2; b++)
            for (int sa = 0; sa < 4; sa++)
                for (int sc = 0; sc < 4; sc++)
                    run_case(b, sa, sc, (b * 97 + sa * 13 + sc * 5) % 1024, (sa + sc) % 2,
                             (sa * 11 + sc) % 64, (sc + 1) % 4, (sa + sc) % 3, 5,
                             16'h0100 | 16'(sc), (sc % 2) == 1, 1'b0);

        // R8: error bit set, other status bits irrelevant
        run_case(1, 2, 3, 300, 1, 17, 2, 1, 4, 16'h0400, 1'b0, 1'b0);
        run_case(0, 0, 0, 5, 0, 63, 3, 0, 4, 16'hFFFF, 1'b1, 1'b0);
        run_case(0, 1, 2, 6, 0, 9, 1, 2, 4, 16'hFBFF, 1'b0, 1'b0);
        // R9: timeout edges
        run_case(0, 1, 1, 77, 0, 3, 1, 5, 2, 16'h0000, 1'b0, 1'b0);
        run_case(1, 0, 1, 78, 1, 4, 0, 3, 0, 16'h0000, 1'b0, 1'b0);
        run_case(1, 3, 1, 79, 0, 5, 2, 3, 3, 16'h0000, 1'b0, 1'b0);
        run_case(0, 3, 2, 80, 1, 6, 3, 2, 3, 16'h0000, 1'b1, 1'b0);
        // R12: start ignored while busy
        run_case(1, 1, 2, 512, 1, 40, 2, 1, 6, 16'h0000, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++;
        n_err++;
        $display("FAIL R12 watchdog actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule